// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block converts a segment plus a 16-bit offset into a 24-bit physical address. It works in one of two modes. In real mode the segment value is multiplied by sixteen and added to the offset, and no protection applies. In protected mode the block uses a descriptor that was loaded earlier. The descriptor holds a base, a limit and a rights byte. The block checks the requested access against the descriptor and, if every check passes, adds the base to the offset.

A small state machine tracks the mode. It has two states, `MODE_REAL` and `MODE_PROT`. Reset puts it in `MODE_REAL`. On every clock edge it takes the transition `go_prot` (from `MODE_REAL` to `MODE_PROT`) when the mode input is high, and the transition `go_real` (from `MODE_PROT` to `MODE_REAL`) when the mode input is low. A request is translated in the mode the machine holds at that edge. The result appears on registered outputs one cycle later, together with a valid flag and a fault code.

Top module: `seg_xlat_unit`

## Requirements
- R1: After reset the outputs are zero and the unit is in real mode. A request presented in the first cycle after reset is translated as real mode, even if `prot_req_i` is high in that same cycle.
- R2: In real mode the address is ((segment << 4) + offset) mod 2^20, with bits 23:20 equal to zero. The fault code is 0 for every access kind.
- R3: `prot_req_i` is sampled on every clock edge. A change takes effect for requests presented in the next cycle.
- R4: A load (`desc_load_i` high) captures limit, base and rights, and the descriptor holds until the next load. A request in the same cycle as a load uses the previous descriptor. After reset the descriptor is all zeros.
- R5: In protected mode, when all checks pass, the address is (base + offset) mod 2^24.
- R6: Rights bit 7 (present) equal to 0 gives fault code 1.
- R7: Wrong type gives fault code 2. Access kind is encoded 0 read, 1 write, 2 execute, 3 treated as read. The type is wrong when rights bit 4 is 0 (system or gate descriptor), when the kind is execute and rights bit 3 is 0 (data segment), or when the kind is write and rights bit 3 is 1 (code segment).
- R8: If the current privilege level is greater than rights bits 6:5, the fault code is 4.
- R9: If the offset is greater than the limit, the fault code is 3. An offset equal to the limit passes.
- R10: When several checks fail, the code reported follows the priority present, then type, then privilege, then limit.
- R11: Results appear one cycle after the request. `addr_valid_o` is high only when the fault code is 0, and the address reads 0 whenever `addr_valid_o` is low.
- R12: A cycle without a request gives `addr_valid_o` 0, fault code 0 and address 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_req_i | input | 1 | Mode select: 1 protected, 0 real |
| desc_load_i | input | 1 | Load the descriptor fields below |
| desc_limit_i | input | 16 | Descriptor limit |
| desc_base_i | input | 24 | Descriptor base |
| desc_rights_i | input | 8 | Descriptor rights byte |
| seg_value_i | input | 16 | Segment value used in real mode |
| req_valid_i | input | 1 | Access request strobe |
| req_offset_i | input | 16 | Access offset |
| req_kind_i | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| req_cpl_i | input | 2 | Privilege level of the requester |
| phys_addr_o | output | 24 | Translated address |
| addr_valid_o | output | 1 | Address valid (no fault) |
| fault_o | output | 3 | Fault code |

## Verification
Directed cases cover the places where the checks meet:
- offsets just at the limit and one above it;
- a privilege level one step too weak;
- each type mismatch, one per access kind;
- descriptors that fail several checks at once, which shows whether the priority order is respected.

Sums that overflow, in both modes, show whether the address wraps at the right width. A load in the same cycle as a request, and a mode change in the same cycle as a request, show whether the one-cycle ordering holds. Seeded random traffic mixes loads, mode changes and idle cycles. Its rights bytes are random, so every combination of fault bits is reached across all kinds and privilege levels.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    localparam int OFF_W    = 16;
    localparam int LIM_W    = 16;
    localparam int ADDR_W   = 24;
    localparam int RIGHTS_W = 8;
    localparam int PL_W     = 2;

    // rights byte bit positions
    localparam int RB_PRESENT = 7;
    localparam int RB_DPL_HI  = 6;
    localparam int RB_DPL_LO  = 5;
    localparam int RB_USER    = 4;
    localparam int RB_CODE    = 3;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_ABSENT = 3'd1,
        FLT_TYPE   = 3'd2,
        FLT_LIMIT  = 3'd3,
        FLT_PRIV   = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    typedef enum logic {
        MODE_REAL = 1'b0,
        MODE_PROT = 1'b1
    } mode_e;

    typedef struct packed {
        logic [LIM_W-1:0]    limit;
        logic [ADDR_W-1:0]   base;
        logic [RIGHTS_W-1:0] rights;
    } seg_desc_t;

endpackage

// File: rtl/seg_mode_fsm.sv
module seg_mode_fsm
    import seg_xlat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prot_req_i,
    output logic prot_o
);

    mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_REAL: if (prot_req_i)  state_d = MODE_PROT;  // go_prot
            MODE_PROT: if (!prot_req_i) state_d = MODE_REAL;  // go_real
            default:                    state_d = MODE_REAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_REAL;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            MODE_PROT: prot_o = 1'b1;
            default:   prot_o = 1'b0;
        endcase
    end

    // R3: the mode seen at an edge is the request sampled one edge before
    assert_mode_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (prot_o == $past(prot_req_i)));

endmodule

// File: rtl/seg_desc_reg.sv
module seg_desc_reg
    import seg_xlat_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_i,
    input  seg_desc_t desc_i,
    output seg_desc_t desc_o
);

    seg_desc_t desc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      desc_q <= '0;
        else if (load_i) desc_q <= desc_i;
    end

    assign desc_o = desc_q;

    assert_desc_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(desc_q));

    assert_desc_captures_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (desc_q == $past(desc_i)));

endmodule

// File: rtl/seg_prot_check.sv
module seg_prot_check
    import seg_xlat_pkg::*;
#(
    parameter int OFFSET_W = OFF_W
) (
    input  logic                prot_i,
    input  seg_desc_t           desc_i,
    input  logic [OFFSET_W-1:0] offset_i,
    input  logic [1:0]          kind_i,
    input  logic [PL_W-1:0]     cpl_i,
    output fault_e              fault_o
);

    logic            absent;
    logic            bad_type;
    logic            bad_priv;
    logic            over_limit;
    logic [PL_W-1:0] dpl;

    always_comb begin
        dpl        = desc_i.rights[RB_DPL_HI:RB_DPL_LO];
        absent     = !desc_i.rights[RB_PRESENT];
        bad_type   = !desc_i.rights[RB_USER]
                   || ((acc_e'(kind_i) == ACC_EXEC)  && !desc_i.rights[RB_CODE])
                   || ((acc_e'(kind_i) == ACC_WRITE) &&  desc_i.rights[RB_CODE]);
        bad_priv   = cpl_i > dpl;
        over_limit = {{(OFFSET_W > LIM_W ? 0 : LIM_W - OFFSET_W){1'b0}}, offset_i}
                     > desc_i.limit;
    end

    // priority: present, type, privilege, limit (R10)
    always_comb begin
        if (!prot_i)         fault_o = FLT_NONE;
        else if (absent)     fault_o = FLT_ABSENT;
        else if (bad_type)   fault_o = FLT_TYPE;
        else if (bad_priv)   fault_o = FLT_PRIV;
        else if (over_limit) fault_o = FLT_LIMIT;
        else                 fault_o = FLT_NONE;
    end

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
    import seg_xlat_pkg::*;
#(
    parameter int SEG_SHIFT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prot_req_i,
    input  logic                desc_load_i,
    input  logic [LIM_W-1:0]    desc_limit_i,
    input  logic [ADDR_W-1:0]   desc_base_i,
    input  logic [RIGHTS_W-1:0] desc_rights_i,
    input  logic [OFF_W-1:0]    seg_value_i,
    input  logic                req_valid_i,
    input  logic [OFF_W-1:0]    req_offset_i,
    input  logic [1:0]          req_kind_i,
    input  logic [PL_W-1:0]     req_cpl_i,
    output logic [ADDR_W-1:0]   phys_addr_o,
    output logic                addr_valid_o,
    output logic [2:0]          fault_o
);

    localparam int REAL_W = OFF_W + SEG_SHIFT;

    logic              prot;
    seg_desc_t         desc_in, desc_cur;
    fault_e            fault_c;
    logic [REAL_W-1:0] real_sum;
    logic [ADDR_W-1:0] addr_c;

    logic [ADDR_W-1:0] addr_q;
    logic              valid_q;
    logic [2:0]        fault_q;

    assign desc_in = '{limit: desc_limit_i, base: desc_base_i, rights: desc_rights_i};

    seg_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .prot_req_i (prot_req_i),
        .prot_o     (prot)
    );

    seg_desc_reg u_desc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (desc_load_i),
        .desc_i (desc_in),
        .desc_o (desc_cur)
    );

    seg_prot_check #(.OFFSET_W(OFF_W)) u_check (
        .prot_i   (prot),
        .desc_i   (desc_cur),
        .offset_i (req_offset_i),
        .kind_i   (req_kind_i),
        .cpl_i    (req_cpl_i),
        .fault_o  (fault_c)
    );

    always_comb begin
        real_sum = {seg_value_i, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, req_offset_i};
        if (prot) addr_c = desc_cur.base + {{(ADDR_W - OFF_W){1'b0}}, req_offset_i};
        else      addr_c = {{(ADDR_W - REAL_W){1'b0}}, real_sum};
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid_i) begin
            addr_q  <= '0;
            valid_q <= 1'b0;
            fault_q <= FLT_NONE;
        end else begin
            fault_q <= fault_c;
            valid_q <= (fault_c == FLT_NONE);
            addr_q  <= (fault_c == FLT_NONE) ? addr_c : '0;
        end
    end

    assign phys_addr_o  = addr_q;
    assign addr_valid_o = valid_q;
    assign fault_o      = fault_q;

    assert_real_no_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !prot) |=> (fault_o == 3'd0 && addr_valid_o
                                    && phys_addr_o[ADDR_W-1:REAL_W] == '0));

    assert_fault_blocks_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o != 3'd0) |-> (!addr_valid_o && phys_addr_o == '0));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!addr_valid_o && fault_o == 3'd0 && phys_addr_o == '0));

    assert_absent_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && prot && !desc_cur.rights[RB_PRESENT]) |=> (fault_o == 3'd1));

endmodule

// File: tb/seg_xlat_unit_tb_top.sv
`timescale 1ns/1ps
module seg_xlat_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        prot_req_i, desc_load_i, req_valid_i;
    logic [15:0] desc_limit_i, seg_value_i, req_offset_i;
    logic [23:0] desc_base_i;
    logic [7:0]  desc_rights_i;
    logic [1:0]  req_kind_i, req_cpl_i;
    logic [23:0] phys_addr_o;
    logic        addr_valid_o;
    logic [2:0]  fault_o;

    int checks = 0;
    int fails  = 0;

    // bench-side state model
    logic        m_prot;
    logic [15:0] m_lim;
    logic [23:0] m_base;
    logic [7:0]  m_rights;

    always #10 clk = ~clk;

    seg_xlat_unit dut_i (
        .clk(clk), .rst_n(rst_n), .prot_req_i(prot_req_i), .desc_load_i(desc_load_i),
        .desc_limit_i(desc_limit_i), .desc_base_i(desc_base_i), .desc_rights_i(desc_rights_i),
        .seg_value_i(seg_value_i), .req_valid_i(req_valid_i), .req_offset_i(req_offset_i),
        .req_kind_i(req_kind_i), .req_cpl_i(req_cpl_i),
        .phys_addr_o(phys_addr_o), .addr_valid_o(addr_valid_o), .fault_o(fault_o)
    );

    // returns {valid, fault[2:0], addr[23:0]}
    function automatic logic [27:0] expect_out(input logic prot, input logic [15:0] lim,
            input logic [23:0] base, input logic [7:0] rb, input logic [15:0] seg,
            input logic vld, input logic [15:0] off, input logic [1:0] kind,
            input logic [1:0] cpl);
        logic [2:0]  f;
        logic [23:0] a;
        logic [20:0] rs;
        if (!vld) return 28'd0;
        f = 3'd0;
        if (prot) begin
            if (rb[7] == 1'b0) f = 3'd1;
            else if (rb[4] == 1'b0 || (kind == 2'd2 && !rb[3]) || (kind == 2'd1 && rb[3])) f = 3'd2;
            else if (cpl > rb[6:5]) f = 3'd4;
            else if (off > lim) f = 3'd3;
        end
        rs = {1'b0, seg, 4'h0} + {5'd0, off};
        a  = prot ? (base + {8'd0, off}) : {4'd0, rs[19:0]};
        if (f != 3'd0) return {1'b0, f, 24'd0};
        return {1'b1, f, a};
    endfunction

    // called at a negedge; drives, waits one cycle, compares at the next negedge
    task automatic step(input string tag, input logic mode, input logic ld,
            input logic [15:0] lim, input logic [23:0] base, input logic [7:0] rb,
            input logic [15:0] seg, input logic vld, input logic [15:0] off,
            input logic [1:0] kind, input logic [1:0] cpl);
        logic [27:0] e;
        e = expect_out(m_prot, m_lim, m_base, m_rights, seg, vld, off, kind, cpl);
        prot_req_i = mode; desc_load_i = ld; desc_limit_i = lim; desc_base_i = base;
        desc_rights_i = rb; seg_value_i = seg; req_valid_i = vld; req_offset_i = off;
        req_kind_i = kind; req_cpl_i = cpl;
        @(negedge clk);
        m_prot = mode;
        if (ld) begin m_lim = lim; m_base = base; m_rights = rb; end
        checks++;
        if ({addr_valid_o, fault_o, phys_addr_o} !== e) begin
            fails++;
            $display("FAIL %s: got valid=%0b fault=%0d addr=%06h, expected valid=%0b fault=%0d addr=%06h",
                     tag, addr_valid_o, fault_o, phys_addr_o, e[27], e[26:24], e[23:0]);
        end
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; prot_req_i = 1'b0; desc_load_i = 1'b0; desc_limit_i = '0;
        desc_base_i = '0; desc_rights_i = '0; seg_value_i = '0; req_valid_i = 1'b0;
        req_offset_i = '0; req_kind_i = '0; req_cpl_i = '0;
        m_prot = 1'b0; m_lim = '0; m_base = '0; m_rights = '0;
        repeat (3) @(negedge clk);
        checks++;
        if ({addr_valid_o, fault_o, phys_addr_o} !== 28'd0) begin
            fails++;
            $display("FAIL R1 reset: got %07h, expected 0000000", {addr_valid_o, fault_o, phys_addr_o});
        end
        rst_n = 1'b1;

        // R1: mode request in the first cycle does not affect this request
        step("R1", 1'b1, 1'b0, 16'h0, 24'h0, 8'h0, 16'h1234, 1'b1, 16'h0005, 2'd0, 2'd3);
        // R3: now protected; zero descriptor is absent
        step("R3", 1'b0, 1'b0, 16'h0, 24'h0, 8'h0, 16'h1234, 1'b1, 16'h0005, 2'd0, 2'd0);
        // R2: wrap at 20 bits, write and execute both allowed
        step("R2", 1'b0, 1'b0, 16'h0, 24'h0, 8'h0, 16'hFFFF, 1'b1, 16'hFFFF, 2'd1, 2'd3);
        step("R2", 1'b1, 1'b0, 16'h0, 24'h0, 8'h0, 16'hA000, 1'b1, 16'h0123, 2'd2, 2'd0);
        // R4: load with request in the same cycle uses the old (absent) descriptor
        step("R4", 1'b1, 1'b1, 16'h00FF, 24'h123400, 8'hF2, 16'h0, 1'b1, 16'h0010, 2'd0, 2'd3);
        // R5/R9: offset equal to limit passes
        step("R9", 1'b1, 1'b0, 16'h0, 24'h0, 8'h0, 16'h0, 1'b1, 16'h00FF, 2'd0, 2'd3);
        step("R9", 1'b1, 1'b0, 16'h0, 24'h0, 8'h0, 16'h0, 1'b1, 16'h0100, 2'd0, 2'd3);
        step("R5", 1'b1, 1'b0, 16'h0, 24'h0, 8'h0, 16'h0, 1'b1, 16'h0040, 2'd1, 2'd2);
        // R7: execute from data, then code segment written
        step("R7", 1'b1, 1'b0, 16'h0, 24'h0, 8'h0, 16'h0, 1'b1, 16'h0040, 2'd2, 2'd0);
        step("R12", 1'b1, 1'b1, 16'hFFFF, 24'h050000, 8'hF8, 16'h0, 1'b0, 16'h0, 2'd0, 2'd0);
        step("R7", 1'b1, 1'b0, 16'h0, 24'h0, 8'h0, 16'h0, 1'b1, 16'h0040, 2'd1, 2'd0);
        step("R5", 1'b1, 1'b0, 16'h0, 24'h0, 8'h0, 16'h0, 1'b1, 16'h0040, 2'd2, 2'd3);
        // R7: system descriptor
        step("R12", 1'b1, 1'b1, 16'hFFFF, 24'h0, 8'hE2, 16'h0, 1'b0, 16'h0, 2'd0, 2'd0);
        step("R7", 1'b1, 1'b0, 16'h0, 24'h0, 8'h0, 16'h0, 1'b1, 16'h0001, 2'd0, 2'd0);
        // R8: dpl 1, cpl 2 faults, cpl 1 passes
        step("R12", 1'b1, 1'b1, 16'h0FFF, 24'h200000, 8'hB2, 16'h0, 1'b0, 16'h0, 2'd0, 2'd0);
        step("R8", 1'b1, 1'b0, 16'h0, 24'h0, 8'h0, 16'h0, 1'b1, 16'h0001, 2'd0, 2'd2);
        step("R8", 1'b1, 1'b0, 16'h0, 24'h0, 8'h0, 16'h0, 1'b1, 16'h0001, 2'd0, 2'd1);
        // R10: priority combinations
        step("R12", 1'b1, 1'b1, 16'h0000, 24'h0, 8'h02, 16'h0, 1'b0, 16'h0, 2'd0, 2'd0);
        step("R10", 1'b1, 1'b0, 16'h0, 24'h0, 8'h0, 16'h0, 1'b1, 16'h0100, 2'd2, 2'd3);
        step("R12", 1'b1, 1'b1, 16'h0000, 24'h0, 8'h82, 16'h0, 1'b0, 16'h0, 2'd0, 2'd0);
        step("R10", 1'b1, 1'b0, 16'h0, 24'h0, 8'h0, 16'h0, 1'b1, 16'h0100, 2'd0, 2'd3);
        step("R12", 1'b1, 1'b1, 16'h0000, 24'h0, 8'h92, 16'h0, 1'b0, 16'h0, 2'd0, 2'd0);
        step("R10", 1'b1, 1'b0, 16'h0, 24'h0, 8'h0, 16'h0, 1'b1, 16'h0100, 2'd0, 2'd3);
        // R5: 24-bit wrap
        step("R12", 1'b1, 1'b1, 16'hFFFF, 24'hFFFF00, 8'hF2, 16'h0, 1'b0, 16'h0, 2'd0, 2'd0);
        step("R5", 1'b1, 1'b0, 16'h0, 24'h0, 8'h0, 16'h0, 1'b1, 16'h0200, 2'd0, 2'd3);
        // R6 with R11: absent after a passing result
        step("R12", 1'b1, 1'b1, 16'hFFFF, 24'h0, 8'h7A, 16'h0, 1'b0, 16'h0, 2'd0, 2'd0);
        step("R6", 1'b1, 1'b0, 16'h0, 24'h0, 8'h0, 16'h0, 1'b1, 16'h0002, 2'd0, 2'd0);
        // back to real mode: change takes effect one cycle later (R3)
        step("R3", 1'b0, 1'b0, 16'h0, 24'h0, 8'h0, 16'h0100, 1'b1, 16'h0002, 2'd0, 2'd0);
        step("R3", 1'b0, 1'b0, 16'h0, 24'h0, 8'h0, 16'h0100, 1'b1, 16'h0002, 2'd0, 2'd0);

        // random traffic (R11 and all checks)
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            step("R11", ($urandom % 5) != 0, (r[3:0] == 4'd0),
                 ($urandom % 2) ? 16'($urandom) : 16'($urandom % 512), 24'($urandom),
                 (r[5]) ? (8'($urandom) | 8'h90) : 8'($urandom),
                 16'($urandom), (r[9:8] != 2'd0), 16'($urandom % 1024),
                 2'($urandom), 2'($urandom));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule